// File: doc/BRIEF.md
# Three-Port Width-Converting Crossbar Slice

This block is one bit-slice of a data crossbar. It links three ports of different widths: a 16-bit memory port, an 8-bit processor port and a 4-bit I/O port. Data moves in bursts of eight 4-bit nibbles, D0 to D7. The memory port carries a burst as two words, D0..D3 and then D4..D7, with D0 in bits [3:0] of the first word. The processor port carries one nibble pair per cycle, with the even nibble in bits [3:0]. The I/O port carries one nibble per cycle. Every port is split into an input, an output and a registered output enable, so the pads outside the block stay undriven unless the slice selects that port.

A 4-bit command is sampled on each rising clock edge and selects one route. The routes are memory to I/O, memory to processor, processor to memory, I/O to memory, processor to I/O (single byte or burst), I/O to processor (single byte or burst), two test forms, idle and reset. Routes that read from memory take their data from a read buffer. A read strobe fills that buffer one word per pulse. Routes that write to memory fill a write buffer. A write strobe then drives that buffer onto the memory port one word per pulse. Both strobes work on their own, so they can overlap any route.

Top module: `xbar_slice`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, prc_oe, io_oe and mem_oe are all 0.
- R2: Command codes 0 and 11 to 14 are idle. They start no route and drive no port.
- R3: Each mem_rd_stb pulse loads mem_in into the read buffer: the first pulse after reset loads D0..D3, the next loads D4..D7. Command 1, accepted at edge E0, drives Dk on io_out with io_oe=1 after edge E(k+1), for k=0..7. io_oe falls after E9.
- R4: Command 2 drives pair k (Dk*2 in bits [3:0], Dk*2+1 in bits [7:4]) from the read buffer on prc_out with prc_oe=1 after edge E(k+1), for k=0..3.
- R5: Command 3 samples prc_in at E1..E4 as pairs 0..3 into the write buffer. Each mem_wr_stb pulse drives the next write-buffer word (D0..D3 first) on mem_out with mem_oe=1 in the following cycle. mem_oe is 0 in every other cycle that no test command drives it.
- R6: Command 4 samples io_in at E1..E8 as D0..D7 into the write buffer.
- R7: Command 5 samples a byte from prc_in at E1. It drives the low nibble on io_out after E2 and the high nibble after E3.
- R8: Command 6 samples prc_in at E1..E4 as pairs 0..3. It drives D0..D7 on io_out after E2..E9.
- R9: Command 7 samples io_in at E1 (D0) and at E2 (D1). It drives the byte {D1,D0} on prc_out after E3.
- R10: Command 8 samples io_in at E1..E8. It holds prc_oe high after E3 through E9 and shows pair k on prc_out after E(2k+3).
- R11: While a route is in progress, any command other than reset is ignored. The burst completes unchanged and the ignored command has no later effect.
- R12: Command 9 (and command 10) samples prc_in at the same edge that accepts it. For one cycle after that edge it drives the byte twice on mem_out, unless a write strobe drives mem_out in that cycle. In the same cycle it drives bits [3:0] of the byte (bits [7:4] for command 10) on io_out.
- R13: Command 15 is accepted even during a route. It aborts the route, turns off every output enable in the next cycle and returns both buffer word pointers to the first word.
- R14: prc_oe and io_oe are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 4 | Route command, sampled each edge |
| mem_rd_stb | input | 1 | Load next word from mem_in into read buffer |
| mem_wr_stb | input | 1 | Drive next write-buffer word onto memory port |
| mem_in | input | 16 | Memory port input |
| mem_out | output | 16 | Memory port output |
| mem_oe | output | 1 | Memory port output enable |
| prc_in | input | 8 | Processor port input |
| prc_out | output | 8 | Processor port output |
| prc_oe | output | 1 | Processor port output enable |
| io_in | input | 4 | I/O port input |
| io_out | output | 4 | I/O port output |
| io_oe | output | 1 | I/O port output enable |

## Verification
The assertions assume that the command input is stable around each rising edge. They also assume that the source port holds valid data on the edges the requirements name for sampling. The bench drives every input only on falling edges and presents each source beat before the edge that samples it. It fills the read buffer with exactly two strobe pulses before any memory-read route, and it drains the write buffer with pairs of write-strobe pulses, so both word pointers start on the first word. The only exception is the deliberate single pulses that exercise the pointer clear of the reset command.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int BEATS     = 8;            // nibbles per burst
    localparam int PAIRS     = BEATS / 2;    // processor beats per burst
    localparam int WORD_NIBS = 4;            // nibbles per memory word
    localparam int CNT_W     = $clog2(BEATS + 2);

    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_M2I    = 4'd1,
        OP_M2P    = 4'd2,
        OP_P2M    = 4'd3,
        OP_I2M    = 4'd4,
        OP_P2I_S  = 4'd5,
        OP_P2I_B  = 4'd6,
        OP_I2P_S  = 4'd7,
        OP_I2P_B  = 4'd8,
        OP_TEST_E = 4'd9,
        OP_TEST_O = 4'd10,
        OP_RESET  = 4'd15
    } op_e;

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode
    import xbar_pkg::*;
(
    input  logic [3:0]       cmd_i,
    output op_e              op_o,
    output logic [CNT_W-1:0] len_o
);

    localparam logic [CNT_W-1:0] LEN_NIB  = CNT_W'(BEATS);
    localparam logic [CNT_W-1:0] LEN_PAIR = CNT_W'(PAIRS);
    localparam logic [CNT_W-1:0] LEN_SGL  = CNT_W'(3);
    localparam logic [CNT_W-1:0] LEN_XB   = CNT_W'(BEATS + 1);

    always_comb begin
        op_o  = OP_IDLE;
        len_o = '0;
        case (cmd_i)
            4'd1:  begin op_o = OP_M2I;    len_o = LEN_NIB;  end
            4'd2:  begin op_o = OP_M2P;    len_o = LEN_PAIR; end
            4'd3:  begin op_o = OP_P2M;    len_o = LEN_PAIR; end
            4'd4:  begin op_o = OP_I2M;    len_o = LEN_NIB;  end
            4'd5:  begin op_o = OP_P2I_S;  len_o = LEN_SGL;  end
            4'd6:  begin op_o = OP_P2I_B;  len_o = LEN_XB;   end
            4'd7:  begin op_o = OP_I2P_S;  len_o = LEN_SGL;  end
            4'd8:  begin op_o = OP_I2P_B;  len_o = LEN_XB;   end
            4'd9:  op_o = OP_TEST_E;
            4'd10: op_o = OP_TEST_O;
            4'd15: op_o = OP_RESET;
            default: op_o = OP_IDLE;   // R2: unused codes behave as idle
        endcase
    end

endmodule

// File: rtl/xbar_route.sv
module xbar_route
    import xbar_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  op_e                    op_i,
    input  logic [CNT_W-1:0]       len_i,
    input  logic [2*NIB_W-1:0]     prc_in_i,
    input  logic [NIB_W-1:0]       io_in_i,
    input  logic [BEATS*NIB_W-1:0] rb_data_i,
    output logic [2*NIB_W-1:0]     prc_out_o,
    output logic                   prc_oe_o,
    output logic [NIB_W-1:0]       io_out_o,
    output logic                   io_oe_o,
    output logic [BEATS-1:0]       wb_we_o,
    output logic [BEATS*NIB_W-1:0] wb_data_o,
    output logic                   tmem_en_o,
    output logic [4*NIB_W-1:0]     tmem_word_o,
    output logic                   clr_o,
    output logic                   busy_o
);

    localparam int PW = 2 * NIB_W;
    localparam int BW = BEATS * NIB_W;

    typedef struct packed {
        logic             active;
        op_e              op;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
        logic [BW-1:0]    stage;
        logic [PW-1:0]    prc_out;
        logic             prc_oe;
        logic [NIB_W-1:0] io_out;
        logic             io_oe;
    } route_s;

    route_s q, d;
    int     ci;

    always_comb begin
        d           = q;
        d.prc_oe    = 1'b0;
        d.io_oe     = 1'b0;
        wb_we_o     = '0;
        wb_data_o   = '0;
        tmem_en_o   = 1'b0;
        tmem_word_o = {prc_in_i, prc_in_i};
        clr_o       = 1'b0;
        ci          = int'(q.cnt);

        if (op_i == OP_RESET) begin
            d.active = 1'b0;
            clr_o    = 1'b1;
        end else if (!q.active) begin
            case (op_i)
                OP_IDLE: ;
                OP_TEST_E, OP_TEST_O: begin
                    d.io_oe   = 1'b1;
                    d.io_out  = (op_i == OP_TEST_E) ? prc_in_i[NIB_W-1:0]
                                                    : prc_in_i[PW-1:NIB_W];
                    tmem_en_o = 1'b1;
                end
                default: begin
                    d.active = 1'b1;
                    d.op     = op_i;
                    d.cnt    = '0;
                    d.last   = len_i - 1'b1;
                end
            endcase
        end else begin
            case (q.op)
                OP_M2I: begin
                    d.io_out = rb_data_i[ci*NIB_W +: NIB_W];
                    d.io_oe  = 1'b1;
                end
                OP_M2P: begin
                    d.prc_out = rb_data_i[ci*PW +: PW];
                    d.prc_oe  = 1'b1;
                end
                OP_P2M: begin
                    wb_we_o[2*ci +: 2]     = 2'b11;
                    wb_data_o[ci*PW +: PW] = prc_in_i;
                end
                OP_I2M: begin
                    wb_we_o[ci]                  = 1'b1;
                    wb_data_o[ci*NIB_W +: NIB_W] = io_in_i;
                end
                OP_P2I_S: begin
                    if (ci == 0) begin
                        d.stage[PW-1:0] = prc_in_i;
                    end else begin
                        d.io_out = q.stage[(ci-1)*NIB_W +: NIB_W];
                        d.io_oe  = 1'b1;
                    end
                end
                OP_P2I_B: begin
                    if (ci < PAIRS) d.stage[ci*PW +: PW] = prc_in_i;
                    if (ci >= 1) begin
                        d.io_out = q.stage[(ci-1)*NIB_W +: NIB_W];
                        d.io_oe  = 1'b1;
                    end
                end
                OP_I2P_S: begin
                    if (ci < 2) begin
                        d.stage[ci*NIB_W +: NIB_W] = io_in_i;
                    end else begin
                        d.prc_out = q.stage[PW-1:0];
                        d.prc_oe  = 1'b1;
                    end
                end
                OP_I2P_B: begin
                    if (ci < BEATS) d.stage[ci*NIB_W +: NIB_W] = io_in_i;
                    if (ci >= 2) begin
                        d.prc_oe = 1'b1;
                        if (ci % 2 == 0) d.prc_out = q.stage[(ci/2-1)*PW +: PW];
                    end
                end
                default: ;
            endcase
            if (q.cnt == q.last) d.active = 1'b0;
            else                 d.cnt    = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.op     <= OP_IDLE;
        end else begin
            q <= d;
        end
    end

    assign prc_out_o = q.prc_out;
    assign prc_oe_o  = q.prc_oe;
    assign io_out_o  = q.io_out;
    assign io_oe_o   = q.io_oe;
    assign busy_o    = q.active;

    // R14: the two narrow ports are never both destinations
    assert_dest_exclusive_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !(prc_oe_o && io_oe_o));

    // R11: a non-reset command during a burst leaves the route in place
    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.cnt != q.last && op_i != OP_RESET) |=> (q.active && $stable(q.op)));

    // R13: reset command silences the narrow ports on the next cycle
    assert_reset_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RESET) |=> (!q.active && !prc_oe_o && !io_oe_o));

    // R3: memory-to-I/O keeps the I/O port driven for every beat
    assert_m2i_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.op == OP_M2I && op_i != OP_RESET) |=> io_oe_o);

    // R12: an accepted test command drives the I/O port next cycle
    assert_test_io_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.active && (op_i == OP_TEST_E || op_i == OP_TEST_O)) |=> io_oe_o);

endmodule

// File: rtl/xbar_membuf.sv
module xbar_membuf
    import xbar_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_stb_i,
    input  logic                   wr_stb_i,
    input  logic [4*NIB_W-1:0]     mem_in_i,
    input  logic [BEATS-1:0]       wb_we_i,
    input  logic [BEATS*NIB_W-1:0] wb_data_i,
    input  logic                   tmem_en_i,
    input  logic [4*NIB_W-1:0]     tmem_word_i,
    input  logic                   clr_i,
    output logic [BEATS*NIB_W-1:0] rb_data_o,
    output logic [4*NIB_W-1:0]     mem_out_o,
    output logic                   mem_oe_o
);

    localparam int MW = WORD_NIBS * NIB_W;
    localparam int BW = BEATS * NIB_W;

    typedef struct packed {
        logic [BW-1:0] rb;
        logic          rp;
        logic [BW-1:0] wb;
        logic          wp;
        logic [MW-1:0] mem_out;
        logic          mem_oe;
    } buf_s;

    buf_s          q, d;
    logic [BW-1:0] wb_merged;

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        assign wb_merged[g*NIB_W +: NIB_W] = wb_we_i[g] ? wb_data_i[g*NIB_W +: NIB_W]
                                                        : q.wb[g*NIB_W +: NIB_W];
    end

    always_comb begin
        d        = q;
        d.mem_oe = 1'b0;
        d.wb     = wb_merged;
        if (clr_i) begin
            d.rp = 1'b0;
            d.wp = 1'b0;
        end else begin
            if (rd_stb_i) begin
                d.rb[(q.rp ? MW : 0) +: MW] = mem_in_i;
                d.rp = ~q.rp;
            end
            if (wr_stb_i) begin
                d.mem_out = q.wb[(q.wp ? MW : 0) +: MW];
                d.mem_oe  = 1'b1;
                d.wp      = ~q.wp;
            end else if (tmem_en_i) begin
                d.mem_out = tmem_word_i;
                d.mem_oe  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rb_data_o = q.rb;
    assign mem_out_o = q.mem_out;
    assign mem_oe_o  = q.mem_oe;

    // R5: a write strobe drives the memory port in the following cycle
    assert_wr_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !clr_i) |=> mem_oe_o);

    // R5: with no strobe and no test request the memory port is released
    assert_mem_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb_i && !tmem_en_i) |=> !mem_oe_o);

endmodule

// File: rtl/xbar_slice.sv
module xbar_slice
    import xbar_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           cmd,
    input  logic                 mem_rd_stb,
    input  logic                 mem_wr_stb,
    input  logic [4*NIB_W-1:0]   mem_in,
    output logic [4*NIB_W-1:0]   mem_out,
    output logic                 mem_oe,
    input  logic [2*NIB_W-1:0]   prc_in,
    output logic [2*NIB_W-1:0]   prc_out,
    output logic                 prc_oe,
    input  logic [NIB_W-1:0]     io_in,
    output logic [NIB_W-1:0]     io_out,
    output logic                 io_oe
);

    localparam int BW = BEATS * NIB_W;

    op_e              op;
    logic [CNT_W-1:0] len;
    logic [BW-1:0]    rb_data;
    logic [BEATS-1:0] wb_we;
    logic [BW-1:0]    wb_data;
    logic             tmem_en;
    logic [4*NIB_W-1:0] tmem_word;
    logic             clr;
    logic             busy;

    xbar_decode u_dec (
        .cmd_i (cmd),
        .op_o  (op),
        .len_o (len)
    );

    xbar_route #(.NIB_W(NIB_W)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .len_i       (len),
        .prc_in_i    (prc_in),
        .io_in_i     (io_in),
        .rb_data_i   (rb_data),
        .prc_out_o   (prc_out),
        .prc_oe_o    (prc_oe),
        .io_out_o    (io_out),
        .io_oe_o     (io_oe),
        .wb_we_o     (wb_we),
        .wb_data_o   (wb_data),
        .tmem_en_o   (tmem_en),
        .tmem_word_o (tmem_word),
        .clr_o       (clr),
        .busy_o      (busy)
    );

    xbar_membuf #(.NIB_W(NIB_W)) u_mbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_stb_i    (mem_rd_stb),
        .wr_stb_i    (mem_wr_stb),
        .mem_in_i    (mem_in),
        .wb_we_i     (wb_we),
        .wb_data_i   (wb_data),
        .tmem_en_i   (tmem_en),
        .tmem_word_i (tmem_word),
        .clr_i       (clr),
        .rb_data_o   (rb_data),
        .mem_out_o   (mem_out),
        .mem_oe_o    (mem_oe)
    );

    // R2: an idle-class code while no route runs leaves the narrow ports off
    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (cmd == 4'd0 || (cmd >= 4'd11 && cmd <= 4'd14))) |=> (!prc_oe && !io_oe && !busy));

    // R1: no port is driven in the first cycle after reset release
    assert_powerup_quiet_R1: assert property (@(posedge clk)
        (!rst_n) |=> (!prc_oe && !io_oe && !mem_oe));

endmodule

// File: tb/sim_xbar_slice.sv
module sim_xbar_slice;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = '0;
    logic        mem_rd_stb = 1'b0;
    logic        mem_wr_stb = 1'b0;
    logic [15:0] mem_in = '0;
    logic [15:0] mem_out;
    logic        mem_oe;
    logic [7:0]  prc_in = '0;
    logic [7:0]  prc_out;
    logic        prc_oe;
    logic [3:0]  io_in = '0;
    logic [3:0]  io_out;
    logic        io_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    xbar_slice u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb),
        .mem_in(mem_in), .mem_out(mem_out), .mem_oe(mem_oe),
        .prc_in(prc_in), .prc_out(prc_out), .prc_oe(prc_oe),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    // burst patterns walked by the main loop; D0 is bits [3:0]
    localparam logic [31:0] PATS [4] = '{
        32'h7654_3210, 32'hFEDC_BA98, 32'h5A5A_A5A5, 32'h0F1E_2D3C
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] nib(input logic [31:0] p, input int k);
        return p[k*4 +: 4];
    endfunction

    function automatic logic [7:0] pair(input logic [31:0] p, input int k);
        return p[k*8 +: 8];
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] c);
        cmd = c;
        step();
        cmd = 4'd0;
    endtask

    task automatic load_rb(input logic [31:0] p);
        mem_rd_stb = 1'b1;
        mem_in = p[15:0];
        step();
        mem_in = p[31:16];
        step();
        mem_rd_stb = 1'b0;
    endtask

    task automatic drain_wb(input logic [31:0] p, input string tag);
        mem_wr_stb = 1'b1;
        step();
        chk({tag, " word0"}, {15'd0, mem_oe, mem_out}, {15'd0, 1'b1, p[15:0]});
        step();
        chk({tag, " word1"}, {15'd0, mem_oe, mem_out}, {15'd0, 1'b1, p[31:16]});
        mem_wr_stb = 1'b0;
        step();
        chk({tag, " release"}, {31'd0, mem_oe}, 32'd0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        chk("R1 oe in reset", {29'd0, prc_oe, io_oe, mem_oe}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R1 oe after release", {29'd0, prc_oe, io_oe, mem_oe}, 32'd0);

        // table walk: memory routes per pattern
        for (int i = 0; i < 4; i++) begin
            logic [31:0] p;
            p = PATS[i];
            load_rb(p);
            issue(4'd1);
            for (int k = 0; k < 8; k++) begin
                step();
                chk("R3 m2i nibble", {27'd0, io_oe, io_out}, {27'd0, 1'b1, nib(p, k)});
                chk("R14 m2i prc off", {31'd0, prc_oe}, 32'd0);
            end
            step();
            chk("R3 m2i end", {31'd0, io_oe}, 32'd0);

            issue(4'd2);
            for (int k = 0; k < 4; k++) begin
                step();
                chk("R4 m2p pair", {23'd0, prc_oe, prc_out}, {23'd0, 1'b1, pair(p, k)});
            end
            step();
            chk("R4 m2p end", {31'd0, prc_oe}, 32'd0);

            issue(4'd3);
            for (int k = 0; k < 4; k++) begin
                prc_in = pair(~p, k);
                step();
            end
            chk("R5 p2m no mem drive", {31'd0, mem_oe}, 32'd0);
            drain_wb(~p, "R5 p2m");
        end

        // R6: I/O to memory
        issue(4'd4);
        for (int k = 0; k < 8; k++) begin
            io_in = nib(32'hC3B2_A190, k);
            step();
        end
        drain_wb(32'hC3B2_A190, "R6 i2m");

        // R7: processor to I/O single
        issue(4'd5);
        prc_in = 8'h9E;
        step();
        prc_in = 8'h00;
        step();
        chk("R7 p2i_s low", {27'd0, io_oe, io_out}, {27'd0, 1'b1, 4'hE});
        step();
        chk("R7 p2i_s high", {27'd0, io_oe, io_out}, {27'd0, 1'b1, 4'h9});
        step();
        chk("R7 p2i_s end", {31'd0, io_oe}, 32'd0);

        // R8: processor to I/O burst
        issue(4'd6);
        for (int c = 0; c < 9; c++) begin
            if (c < 4) prc_in = pair(32'h1357_9BDF, c);
            step();
            if (c >= 1) chk("R8 p2i_b nibble", {27'd0, io_oe, io_out}, {27'd0, 1'b1, nib(32'h1357_9BDF, c - 1)});
            chk("R14 p2i_b prc off", {31'd0, prc_oe}, 32'd0);
        end
        step();
        chk("R8 p2i_b end", {31'd0, io_oe}, 32'd0);

        // R9: I/O to processor single
        issue(4'd7);
        io_in = 4'h4;
        step();
        io_in = 4'hB;
        step();
        step();
        chk("R9 i2p_s byte", {23'd0, prc_oe, prc_out}, {23'd0, 1'b1, 8'hB4});
        step();
        chk("R9 i2p_s end", {31'd0, prc_oe}, 32'd0);

        // R10: I/O to processor burst
        issue(4'd8);
        for (int c = 0; c < 9; c++) begin
            if (c < 8) io_in = nib(32'h8E6C_4A20, c);
            step();
            if (c >= 2) chk("R10 i2p_b oe", {31'd0, prc_oe}, 32'd1);
            if (c >= 2 && c % 2 == 0) chk("R10 i2p_b pair", {24'd0, prc_out}, {24'd0, pair(32'h8E6C_4A20, c / 2 - 1)});
            chk("R14 i2p_b io off", {31'd0, io_oe}, 32'd0);
        end
        step();
        chk("R10 i2p_b end", {31'd0, prc_oe}, 32'd0);

        // R2: unused codes and idle
        issue(4'd12);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R2 unused code no drive", {29'd0, prc_oe, io_oe, mem_oe}, 32'd0);
        end
        issue(4'd13);
        step();
        chk("R2 code 13 no drive", {29'd0, prc_oe, io_oe, mem_oe}, 32'd0);

        // R11: command during a burst is ignored
        load_rb(PATS[0]);
        issue(4'd1);
        for (int k = 0; k < 8; k++) begin
            if (k == 3) cmd = 4'd7;
            step();
            cmd = 4'd0;
            chk("R11 burst intact", {27'd0, io_oe, io_out}, {27'd0, 1'b1, nib(PATS[0], k)});
        end
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R11 ignored cmd no effect", {30'd0, prc_oe, io_oe}, 32'd0);
        end

        // R12: test forms
        cmd = 4'd9;
        prc_in = 8'hA6;
        step();
        cmd = 4'd0;
        chk("R12 test mem", {15'd0, mem_oe, mem_out}, {15'd0, 1'b1, 16'hA6A6});
        chk("R12 test even io", {27'd0, io_oe, io_out}, {27'd0, 1'b1, 4'h6});
        step();
        chk("R12 test one cycle", {30'd0, io_oe, mem_oe}, 32'd0);
        cmd = 4'd10;
        prc_in = 8'h3D;
        step();
        cmd = 4'd0;
        chk("R12 test2 mem", {15'd0, mem_oe, mem_out}, {15'd0, 1'b1, 16'h3D3D});
        chk("R12 test2 odd io", {27'd0, io_oe, io_out}, {27'd0, 1'b1, 4'h3});
        step();

        // R13: reset command aborts a burst
        load_rb(PATS[1]);
        issue(4'd1);
        step();
        chk("R13 burst started", {27'd0, io_oe, io_out}, {27'd0, 1'b1, nib(PATS[1], 0)});
        cmd = 4'd15;
        step();
        cmd = 4'd0;
        chk("R13 abort quiet", {29'd0, prc_oe, io_oe, mem_oe}, 32'd0);
        step();
        chk("R13 stays quiet", {29'd0, prc_oe, io_oe, mem_oe}, 32'd0);

        // R13: read pointer cleared
        mem_rd_stb = 1'b1;
        mem_in = 16'hDEAD;
        step();
        mem_rd_stb = 1'b0;
        issue(4'd15);
        load_rb(PATS[3]);
        issue(4'd1);
        step();
        chk("R13 rd ptr cleared", {27'd0, io_oe, io_out}, {27'd0, 1'b1, nib(PATS[3], 0)});
        repeat (8) step();

        // R13: write pointer cleared, buffer contents kept
        issue(4'd3);
        for (int k = 0; k < 4; k++) begin
            prc_in = pair(32'h2468_ACE1, k);
            step();
        end
        mem_wr_stb = 1'b1;
        step();
        mem_wr_stb = 1'b0;
        chk("R5 single strobe", {15'd0, mem_oe, mem_out}, {15'd0, 1'b1, 16'hACE1});
        issue(4'd15);
        drain_wb(32'h2468_ACE1, "R13 wr ptr cleared");

        report();
    end

endmodule